// File: doc/BRIEF.md
# Instruction Parcel Unpacking Buffer

This block sits between instruction memory and the execution pipeline. Whole 128-bit words come back from memory, each holding eight 16-bit instruction parcels. Every returned word lands in an input word register. Its wanted parcels are packed, lowest index first, into a sixteen-parcel assembly queue made of two more 128-bit registers. The pipeline takes parcels from the head of that queue with a valid/ready handshake. The block never refuses a returned word. Instead it decides whether a new memory request may be granted: a request is granted only when the space it could later need is already held for it. A consumer stall fills the queue, and the grant then falls.

Each returned word comes with a sideband that says whether it holds a control transfer which the prefetcher predicted as taken. It also gives the position of that transfer and the low address bits of the jump target. Parcels after the predicted transfer are dropped. The transfer parcel leaves with an out-of-sequence flag, and the next word is entered at the target offset.

A flush input discards the buffered parcels and starts a new stream at a given parcel offset. Words that were granted before the flush and are still in flight are dropped when they return. An interrupt input also discards the buffered parcels. It then presents two fixed parcels: first a link-save instruction, then a transfer to the handler.

Top module: `parcel_unpack_buf`

## Requirements
- R1: After reset no parcel is offered (`par_valid_o` low), and a request made to the empty block is granted in the same cycle.
- R2: Parcels leave in order of word arrival and then of parcel index (index i is bits [16i+15:16i]). Exactly one parcel leaves per cycle in which `par_valid_o` and `par_ready_i` are both high.
- R3: While `par_valid_o` is high and `par_ready_i` is low, the offered parcel and its flag stay unchanged in the next cycle, unless a flush or an interrupt occurs.
- R4: `grant_o` equals `req_i` when the queued parcels plus eight per held or outstanding word come to at most sixteen. Otherwise it is low, and it is always low in a cycle with `flush_i` or `irq_i` high.
- R5: A returned word that is not stale never overwrites parcels still waiting in the input register. No parcel is lost or duplicated under any ready pattern.
- R6: For a word marked with `mem_jmp_i`, parcels above index `mem_jpos_i` are dropped and the parcel at `mem_jpos_i` carries `par_oos_o` = 1. The next word starts at parcel index `mem_jto_i`.
- R7: After a cycle with `flush_i` (and no `irq_i`), no parcel is offered until a new word arrives. Words granted before the flush are dropped when they return. The first new word starts at parcel index `flush_off_i`.
- R8: After a cycle with `irq_i`, the buffered parcels are gone. `IRQ_P0` and then `IRQ_P1` are offered, each with flag 0, ahead of any later word. `irq_i` takes precedence over `flush_i`.
- R9: Every parcel other than a predicted-transfer parcel carries `par_oos_o` = 0. A word without a jump mark delivers all parcels from its start index through index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Prefetcher asks to issue one word request |
| grant_o | output | 1 | Request may proceed; its return is guaranteed room |
| mem_valid_i | input | 1 | A memory word is returned this cycle |
| mem_word_i | input | 128 | Returned word, parcel i in bits [16i+15:16i] |
| mem_jmp_i | input | 1 | Word holds a transfer predicted taken |
| mem_jpos_i | input | 3 | Parcel index of the predicted transfer |
| mem_jto_i | input | 3 | Start parcel index for the following word |
| flush_i | input | 1 | Discard everything and start a new stream |
| flush_off_i | input | 3 | Start parcel index of the first word after a flush |
| irq_i | input | 1 | Interrupt: discard and inject the two fixed parcels |
| par_valid_o | output | 1 | A parcel is offered |
| par_data_o | output | 16 | Offered parcel |
| par_oos_o | output | 1 | Parcels after this one are not sequential |
| par_ready_i | input | 1 | Pipeline takes the offered parcel |

## Verification
The stream is run with a ready that is always high, with a ready that drops one cycle in three, and with a long stall. These patterns separate ordering faults, hold faults on a stalled head, and faults in the grant reservation that would let a returned word overwrite waiting parcels. A section with predicted jumps tests tail dropping, the flag and target-offset entry. Flushes and an interrupt issued while words are in flight tell correct discarding of stale returns apart from parcels that leak from the old stream.

// File: rtl/parcel_unpack_buf.sv
module parcel_unpack_buf #(
  parameter int PW = 16,
  parameter int NP = 8,
  parameter int QW = 2,
  parameter logic [PW-1:0] IRQ_P0 = 16'hF0A1,
  parameter logic [PW-1:0] IRQ_P1 = 16'hF0B2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  output logic             grant_o,
  input  logic             mem_valid_i,
  input  logic [PW*NP-1:0] mem_word_i,
  input  logic             mem_jmp_i,
  input  logic [$clog2(NP)-1:0] mem_jpos_i,
  input  logic [$clog2(NP)-1:0] mem_jto_i,
  input  logic             flush_i,
  input  logic [$clog2(NP)-1:0] flush_off_i,
  input  logic             irq_i,
  output logic             par_valid_o,
  output logic [PW-1:0]    par_data_o,
  output logic             par_oos_o,
  input  logic             par_ready_i
);
  localparam int QN = NP * QW;
  localparam int OW = $clog2(NP);
  localparam int AW = $clog2(NP + 1);
  localparam int CW = $clog2(QN + 1);
  localparam int RW = 4;

  logic [NP-1:0][PW-1:0] a_par;
  logic [NP-1:0]         a_msk, a_flg;
  logic                  a_valid;
  logic [PW:0]           q [QN];
  logic [PW:0]           q_n [QN];
  logic [PW:0]           cmp [NP];
  logic [CW-1:0]         q_cnt;
  logic [AW-1:0]         a_cnt;
  logic [1:0]            inj;
  logic [OW-1:0]         off;
  logic [RW-1:0]         outst, stale;
  logic                  kill, live, pop, inj_pop, a_move;
  int                    base;

  assign kill    = flush_i | irq_i;
  assign live    = mem_valid_i && stale == '0;
  assign pop     = par_valid_o && par_ready_i && inj == 2'd0;
  assign inj_pop = par_valid_o && par_ready_i && inj != 2'd0;
  assign a_move  = a_valid && (QN - int'(q_cnt) + int'(pop) >= int'(a_cnt));
  assign grant_o = req_i && !kill &&
                   (int'(q_cnt) + NP * (int'(a_valid) + int'(outst)) <= QN);

  assign par_valid_o = inj != 2'd0 || q_cnt != '0;
  assign par_data_o  = inj == 2'd2 ? IRQ_P0 : inj == 2'd1 ? IRQ_P1 : q[0][PW-1:0];
  assign par_oos_o   = inj == 2'd0 && q[0][PW];

  always_comb begin
    a_cnt = '0;
    for (int k = 0; k < NP; k++) cmp[k] = '0;
    for (int i = 0; i < NP; i++)
      if (a_msk[i]) begin
        cmp[a_cnt[OW-1:0]] = {a_flg[i], a_par[i]};
        a_cnt = a_cnt + AW'(1);
      end
  end

  always_comb begin
    base = int'(q_cnt) - int'(pop);
    for (int j = 0; j < QN; j++) begin
      q_n[j] = pop ? q[(j + 1 < QN) ? j + 1 : j] : q[j];
      if (a_move && j >= base && j < base + int'(a_cnt)) q_n[j] = cmp[j - base];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_par   <= '0;
      a_msk   <= '0;
      a_flg   <= '0;
      q_cnt   <= '0;
      inj     <= 2'd0;
      off     <= '0;
      outst   <= '0;
      stale   <= '0;
      for (int j = 0; j < QN; j++) q[j] <= '0;
    end else if (kill) begin
      a_valid <= 1'b0;
      q_cnt   <= '0;
      inj     <= irq_i ? 2'd2 : 2'd0;
      off     <= irq_i ? '0 : flush_off_i;
      stale   <= stale + outst - RW'(mem_valid_i);
      outst   <= '0;
    end else begin
      for (int j = 0; j < QN; j++) q[j] <= q_n[j];
      q_cnt <= q_cnt - CW'(pop) + (a_move ? CW'(a_cnt) : CW'(0));
      if (inj_pop) inj <= inj - 2'd1;
      stale <= stale - RW'(mem_valid_i && !live);
      outst <= outst + RW'(grant_o) - RW'(live);
      if (live) begin
        a_valid <= 1'b1;
        a_par   <= mem_word_i;
        for (int i = 0; i < NP; i++) begin
          a_msk[i] <= (i >= int'(off)) && (!mem_jmp_i || i <= int'(mem_jpos_i));
          a_flg[i] <= mem_jmp_i && i == int'(mem_jpos_i);
        end
        off <= mem_jmp_i ? mem_jto_i : '0;
      end else if (a_move) begin
        a_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/parcel_unpack_buf_chk.sv
module parcel_unpack_buf_chk #(
  parameter int PW = 16,
  parameter logic [PW-1:0] P0 = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_i,
  input logic          irq_i,
  input logic          grant_o,
  input logic          par_valid_o,
  input logic [PW-1:0] par_data_o,
  input logic          par_oos_o,
  input logic          par_ready_i,
  input logic          live,
  input logic          a_valid,
  input logic          a_move
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid_o && !par_ready_i && !flush_i && !irq_i |=>
      par_valid_o && $stable(par_data_o) && $stable(par_oos_o)); // R3
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i || irq_i) |-> !grant_o); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    live && !flush_i && !irq_i |-> !a_valid || a_move); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i && !irq_i |=> !par_valid_o); // R7
  AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> par_valid_o && par_data_o == P0 && !par_oos_o); // R8
endmodule

bind parcel_unpack_buf parcel_unpack_buf_chk #(.PW(PW), .P0(IRQ_P0)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .irq_i(irq_i), .grant_o(grant_o),
  .par_valid_o(par_valid_o), .par_data_o(par_data_o), .par_oos_o(par_oos_o),
  .par_ready_i(par_ready_i), .live(live), .a_valid(a_valid), .a_move(a_move)
);

// File: tb/parcel_unpack_buf_bench.sv
module parcel_unpack_buf_bench;
  localparam logic [15:0] P0 = 16'hF0A1;
  localparam logic [15:0] P1 = 16'hF0B2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_i = 0, grant_o, mem_valid_i = 0, mem_jmp_i = 0, flush_i = 0, irq_i = 0;
  logic [127:0] mem_word_i = '0;
  logic [2:0] mem_jpos_i = '0, mem_jto_i = '0, flush_off_i = '0;
  logic par_valid_o, par_oos_o, par_ready_i = 0;
  logic [15:0] par_data_o;

  always #5 clk = ~clk;

  parcel_unpack_buf u_parcel_unpack_buf (.*);

  int vecs = 0, errs = 0;
  bit jumps_en = 0;
  logic [3:0] gp = '0;
  logic [16:0] mq[$], ma[$];
  bit mav = 0, prev_stall = 0;
  int mout = 0, mstale = 0, minj = 0, moff = 0, wcnt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, compared and advanced at every falling edge
  always @(negedge clk) if (rst_n) begin
    automatic bit ev = minj > 0 || mq.size() > 0;
    automatic bit eg = req_i && !flush_i && !irq_i && (mq.size() + 8 * (int'(mav) + mout) <= 16);
    automatic logic [15:0] ed = minj == 2 ? P0 : minj == 1 ? P1 : (mq.size() > 0 ? mq[0][15:0] : 16'h0);
    automatic bit eo = minj == 0 && mq.size() > 0 && mq[0][16];
    automatic bit fire = ev && par_ready_i;
    chk("R4 grant", 32'(grant_o), 32'(eg));
    chk("R2/R5 valid", 32'(par_valid_o), 32'(ev));
    if (ev) begin
      chk(minj > 0 ? "R8 data" : eo ? "R6 data" : prev_stall ? "R3 data" : "R2 data",
          32'(par_data_o), 32'(ed));
      chk(eo ? "R6 flag" : "R9 flag", 32'(par_oos_o), 32'(eo));
    end
    prev_stall = ev && !par_ready_i;
    gp = {gp[2:0], grant_o};
    if (irq_i || flush_i) begin
      mq.delete(); ma.delete(); mav = 0;
      mstale = mstale + mout - int'(mem_valid_i); mout = 0;
      minj = irq_i ? 2 : 0;
      moff = irq_i ? 0 : int'(flush_off_i);
    end else begin
      if (fire) begin
        if (minj > 0) minj--; else void'(mq.pop_front());
      end
      if (mav && 16 - mq.size() >= ma.size()) begin
        foreach (ma[k]) mq.push_back(ma[k]);
        ma.delete(); mav = 0;
      end
      if (mem_valid_i) begin
        if (mstale > 0) mstale--;
        else begin
          automatic int last = mem_jmp_i ? int'(mem_jpos_i) : 7;
          ma.delete();
          for (int i = moff; i <= last; i++)
            ma.push_back({mem_jmp_i && i == last, mem_word_i[16*i +: 16]});
          mav = 1; mout--;
          moff = mem_jmp_i ? int'(mem_jto_i) : 0;
        end
      end
      if (eg) mout++;
    end
  end

  // memory: returns each granted word four cycles later
  initial forever begin
    @(posedge clk); #2;
    mem_valid_i = gp[3];
    mem_jmp_i = 0; mem_jpos_i = '0; mem_jto_i = '0;
    if (gp[3]) begin
      for (int i = 0; i < 8; i++) mem_word_i[16*i +: 16] = 16'(wcnt * 8 + i);
      if (jumps_en && wcnt % 3 == 2) begin
        mem_jmp_i = 1; mem_jpos_i = 3'(4 + wcnt % 4); mem_jto_i = 3'(wcnt % 4);
      end
      wcnt++;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1; req_i = 1;
    @(negedge clk);
    chk("R1 reset valid", 32'(par_valid_o), 0);
    chk("R1 reset grant", 32'(grant_o), 1);
    step(1);
    par_ready_i = 1;
    step(200);                                   // R2 steady stream
    for (int k = 0; k < 300; k++) begin par_ready_i = (k % 3 != 0); step(1); end
    par_ready_i = 0; step(60);                   // R4 stall propagates
    @(negedge clk);
    chk("R4 stalled grant", 32'(grant_o), 0);
    step(1);
    par_ready_i = 1; jumps_en = 1;               // R6 predicted jumps
    for (int k = 0; k < 300; k++) begin par_ready_i = (k % 5 != 1); step(1); end
    flush_i = 1; flush_off_i = 3'd3; step(1); flush_i = 0;   // R7
    @(negedge clk);
    chk("R7 empty after flush", 32'(par_valid_o), 0);
    step(150);
    irq_i = 1; step(1); irq_i = 0;               // R8
    @(negedge clk);
    chk("R8 first injected", 32'(par_data_o), 32'(P0));
    step(10);
    flush_i = 1; irq_i = 1; step(1); flush_i = 0; irq_i = 0;  // R8 precedence
    @(negedge clk);
    chk("R8 irq over flush", 32'(par_valid_o), 1);
    par_ready_i = 0; step(5); par_ready_i = 1;
    step(20);
    flush_i = 1; flush_off_i = 3'd4; step(1); flush_i = 0;
    for (int k = 0; k < 300; k++) begin par_ready_i = (k % 4 != 0); step(1); end
    req_i = 0; step(40);
    summary();
  end
endmodule